// File: doc/BRIEF.md
# Quad Converter Code Register Bank

This block is the digital front end of a four-channel converter. It holds four 8-bit codes, one per channel, and presents all of them in parallel to the analog side at all times. A host reaches the codes over one shared 8-bit data path. Two active-low half-select strobes, a channel-pick line and a direction line decide what happens on each access.

A write behaves like a transparent latch. For as long as a write is decoded, the chosen code register follows the data bus. When the write condition ends, the register keeps the last byte it sampled. When both strobes are low, one byte goes to a channel pair at once. A read drives the stored byte back on a separate data output and raises an output enable; the enable stands in for a three-state driver.

Every input passes through a two-flop synchronizer into the system clock domain. Because of this, the transparency is emulated one sample at a time and trails the bus by a fixed number of clock edges.

Top module: `quad_code_bank`

## Requirements
- R1: With `sel_ab_n` low and `sel_cd_n` high, a write (`rd_wr` low) targets channel A when `pick_first` is high and channel B when it is low. With `sel_cd_n` low and `sel_ab_n` high, the same rule picks C or D.
- R2: While a write condition is held, the chosen code output follows `bus_in`. A value sampled at a rising edge appears on the code output after the third rising edge, counting the sampling edge as the first.
- R3: When the write condition ends, either because the strobe rises or because `rd_wr` rises, the register keeps the last byte sampled while the write was still decoded. A byte that arrives together with the ending edge is not stored.
- R4: With exactly one strobe low and `rd_wr` high, `bus_oe` goes high and `bus_out` carries the stored code of the channel selected as in R1.
- R5: With both strobes low and `rd_wr` low, the byte is written to A and C together when `pick_first` is high, and to B and D together when it is low.
- R6: With both strobes low and `rd_wr` high, no read occurs: `bus_oe` stays low and all four codes hold.
- R7: With both strobes high, all four codes hold and `bus_oe` stays low, whatever `pick_first`, `rd_wr` and `bus_in` are.
- R8: Outside read mode, `bus_oe` is low and `bus_out` is 0x00.
- R9: A synchronous active-high `rst` clears all four codes to 0x00 and drives `bus_oe` low.
- R10: `bus_oe` rises or falls after the third rising edge that follows a change of the control inputs into or out of read mode, with the same latency as R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_ab_n | input | 1 | Active-low strobe for the A/B half |
| sel_cd_n | input | 1 | Active-low strobe for the C/D half |
| pick_first | input | 1 | High picks A or C, low picks B or D |
| rd_wr | input | 1 | High reads, low writes |
| bus_in | input | 8 | Data bus input, bit 7 is the MSB |
| bus_out | output | 8 | Readback data |
| bus_oe | output | 1 | Readback drive enable |
| code_a | output | 8 | Channel A code |
| code_b | output | 8 | Channel B code |
| code_c | output | 8 | Channel C code |
| code_d | output | 8 | Channel D code |

## Verification
The assertions check, on every cycle, four relations between the port history and the outputs. The enable is high only when a single-strobe read was presented three edges earlier. All codes stay stable under a dual-strobe read or an idle bus. A single write to A copies the delayed bus value. A pair write leaves the two paired codes equal. Other behaviour depends on earlier writes and on when a write ends, so only the bench scenarios can show it. This covers the full 13-row mode walk against a model, readback of preloaded values, the keeping of the last byte when the strobe or the direction line rises together with a data change, the exact enable latency, and a reset in the middle of traffic.

// File: rtl/quad_code_bank.sv
module quad_code_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sel_ab_n,
  input  logic         sel_cd_n,
  input  logic         pick_first,
  input  logic         rd_wr,
  input  logic [W-1:0] bus_in,
  output logic [W-1:0] bus_out,
  output logic         bus_oe,
  output logic [W-1:0] code_a,
  output logic [W-1:0] code_b,
  output logic [W-1:0] code_c,
  output logic [W-1:0] code_d
);
  localparam int SW = W + 4;
  localparam logic [SW-1:0] IDLE = {2'b11, 2'b00, {W{1'b0}}};

  logic [SW-1:0] s1, s2;
  logic [W-1:0]  regs [4];
  logic [3:0]    wr;
  logic          ab_n, cd_n, pk, rd, rd_en;
  logic [W-1:0]  dat, rd_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= IDLE;
      s2 <= IDLE;
    end else begin
      s1 <= {sel_ab_n, sel_cd_n, pick_first, rd_wr, bus_in};
      s2 <= s1;
    end
  end

  assign {ab_n, cd_n, pk, rd, dat} = s2;

  assign wr[0] = !rd && !ab_n &&  pk;
  assign wr[1] = !rd && !ab_n && !pk;
  assign wr[2] = !rd && !cd_n &&  pk;
  assign wr[3] = !rd && !cd_n && !pk;
  assign rd_en = rd && (ab_n != cd_n);
  assign rd_sel = !ab_n ? (pk ? regs[0] : regs[1]) : (pk ? regs[2] : regs[3]);

  always_ff @(posedge clk) begin
    for (int i = 0; i < 4; i++) begin
      if (rst)        regs[i] <= '0;
      else if (wr[i]) regs[i] <= dat;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_oe  <= 1'b0;
      bus_out <= '0;
    end else begin
      bus_oe  <= rd_en;
      bus_out <= rd_en ? rd_sel : '0;
    end
  end

  assign code_a = regs[0];
  assign code_b = regs[1];
  assign code_c = regs[2];
  assign code_d = regs[3];

  AST_OE_SINGLE_READ: assert property (@(posedge clk) disable iff (rst) bus_oe |-> ($past(rd_wr, 3) && ($past(sel_ab_n, 3) != $past(sel_cd_n, 3)))); // R4
  AST_DUAL_READ_QUIET: assert property (@(posedge clk) disable iff (rst) (!$past(sel_ab_n, 3) && !$past(sel_cd_n, 3) && $past(rd_wr, 3)) |-> (!bus_oe && $stable(code_a) && $stable(code_b) && $stable(code_c) && $stable(code_d))); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) ($past(sel_ab_n, 3) && $past(sel_cd_n, 3)) |-> (!bus_oe && $stable(code_a) && $stable(code_b) && $stable(code_c) && $stable(code_d))); // R7
  AST_WRITE_A_FOLLOWS: assert property (@(posedge clk) disable iff (rst) (!$past(sel_ab_n, 3) && $past(sel_cd_n, 3) && $past(pick_first, 3) && !$past(rd_wr, 3)) |-> (code_a == $past(bus_in, 3))); // R2
  AST_PAIR_EQUAL: assert property (@(posedge clk) disable iff (rst) (!$past(sel_ab_n, 3) && !$past(sel_cd_n, 3) && !$past(rd_wr, 3)) |-> ($past(pick_first, 3) ? (code_a == code_c) : (code_b == code_d))); // R5
  AST_OUT_QUIET: assert property (@(posedge clk) disable iff (rst) !bus_oe |-> (bus_out == '0)); // R8
endmodule

// File: tb/tb_quad_code_bank.sv
module tb_quad_code_bank;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel_ab_n = 1'b1, sel_cd_n = 1'b1, pick_first = 1'b0, rd_wr = 1'b0;
  logic [7:0] bus_in = 8'h00;
  logic [7:0] bus_out, code_a, code_b, code_c, code_d;
  logic bus_oe;

  int checks = 0;
  int failures = 0;
  logic [7:0] m [4];

  always #2.5 clk = ~clk;

  quad_code_bank #(.W(8)) dut (
    .clk(clk), .rst(rst), .sel_ab_n(sel_ab_n), .sel_cd_n(sel_cd_n),
    .pick_first(pick_first), .rd_wr(rd_wr), .bus_in(bus_in),
    .bus_out(bus_out), .bus_oe(bus_oe),
    .code_a(code_a), .code_b(code_b), .code_c(code_c), .code_d(code_d)
  );

  // {sel_ab_n, sel_cd_n, pick_first, rd_wr}: all 13 mode rows
  localparam logic [3:0] VEC [13] = '{
    4'b0110, 4'b0100, 4'b1010, 4'b1000,
    4'b0111, 4'b0101, 4'b1011, 4'b1001,
    4'b0010, 4'b0000,
    4'b1111, 4'b0011, 4'b0001
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(input logic [3:0] c, input logic [7:0] d);
    {sel_ab_n, sel_cd_n, pick_first, rd_wr} = c;
    bus_in = d;
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic exp_oe(input logic [3:0] c);
    return c[0] && (c[3] != c[2]);
  endfunction

  function automatic int sel_idx(input logic [3:0] c);
    return (!c[3] ? 0 : 2) + (c[1] ? 0 : 1);
  endfunction

  task automatic model(input logic [3:0] c, input logic [7:0] d);
    if (!c[0]) begin
      if (!c[3]) m[c[1] ? 0 : 1] = d;
      if (!c[2]) m[c[1] ? 2 : 3] = d;
    end
  endtask

  task automatic chk_codes(input string tag);
    chk(tag, code_a, m[0]);
    chk(tag, code_b, m[1]);
    chk(tag, code_c, m[2]);
    chk(tag, code_d, m[3]);
  endtask

  task automatic wr_one(input logic [3:0] c, input logic [7:0] d);
    drive(c, d); step(4); model(c, d);
    drive(4'b1100, 8'h00); step(4);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) m[i] = 8'h00;
    step(4);
    rst = 1'b0;
    step(1);
    // R9 reset state
    chk_codes("R9 reset codes");
    chk("R9 reset oe", {7'd0, bus_oe}, 8'd0);

    // preload distinct values, R1 single writes
    wr_one(4'b0110, 8'h11);
    wr_one(4'b0100, 8'h22);
    wr_one(4'b1010, 8'h33);
    wr_one(4'b1000, 8'h44);
    chk_codes("R1 preload");

    for (int i = 0; i < 13; i++) begin
      logic [3:0] c;
      logic [7:0] d;
      string tag;
      c = VEC[i];
      d = 8'hA0 + 8'(i);
      if (c[3] && c[2]) tag = "R7 hold both high";
      else if (!c[3] && !c[2]) tag = c[0] ? "R6 dual read" : "R5 pair write";
      else tag = c[0] ? "R4 read" : "R1 single write";
      drive(c, d);
      step(4);
      model(c, d);
      chk_codes(tag);
      chk(tag, {7'd0, bus_oe}, {7'd0, exp_oe(c)});
      chk(tag, bus_out, exp_oe(c) ? m[sel_idx(c)] : 8'h00);
      drive(4'b1100, 8'h5A);
      step(4);
      chk("R8 idle oe", {7'd0, bus_oe}, 8'd0);
      chk("R8 idle out", bus_out, 8'h00);
      chk_codes("R7 idle hold");
    end

    // R2 transparency: code follows bus while write held
    drive(4'b1010, 8'h01);
    step(4);
    for (int k = 0; k < 4; k++) begin
      bus_in = 8'h10 << k;
      step(2);
      chk("R2 not yet", code_c, k == 0 ? 8'h01 : 8'h10 << (k - 1));
      step(1);
      chk("R2 follows", code_c, 8'h10 << k);
    end
    m[2] = 8'h80;

    // R3 strobe rises with new data: last byte kept
    drive(4'b0100, 8'h66);
    step(4);
    drive(4'b1100, 8'h99);
    step(5);
    m[1] = 8'h66;
    chk("R3 strobe edge keeps", code_b, 8'h66);

    // R3 rd_wr rises with new data: last byte kept, readback shows it
    drive(4'b1000, 8'h77);
    step(4);
    drive(4'b1001, 8'hEE);
    step(5);
    m[3] = 8'h77;
    chk("R3 rw edge keeps", code_d, 8'h77);
    chk("R3 readback", bus_out, 8'h77);
    chk_codes("R3 all codes");

    // R10 enable latency
    drive(4'b1100, 8'h00);
    step(4);
    drive(4'b0111, 8'h00);
    step(2);
    chk("R10 oe not yet high", {7'd0, bus_oe}, 8'd0);
    step(1);
    chk("R10 oe high", {7'd0, bus_oe}, 8'd1);
    chk("R4 read A", bus_out, m[0]);
    drive(4'b1100, 8'h00);
    step(2);
    chk("R10 oe still high", {7'd0, bus_oe}, 8'd1);
    step(1);
    chk("R10 oe low", {7'd0, bus_oe}, 8'd0);

    // R9 reset during a read clears everything
    drive(4'b1011, 8'h00);
    step(4);
    rst = 1'b1;
    step(1);
    for (int i = 0; i < 4; i++) m[i] = 8'h00;
    chk_codes("R9 mid reset codes");
    chk("R9 mid reset oe", {7'd0, bus_oe}, 8'd0);
    drive(4'b1100, 8'h00);
    step(2);
    rst = 1'b0;
    step(4);
    chk_codes("R9 after reset");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule